// File: doc/BRIEF.md
# Branch Target and Link Unit

This unit settles control-transfer instructions for a 32-bit core. From the address of the instruction, its class, a condition selector, a signed displacement, two register operands and the condition flag, it decides whether the transfer is taken. It also computes where execution continues and, for the linking forms, the return address that belongs in the link register.

Every relative destination starts from the instruction address with its two low bits forced to zero. To that base the unit adds the displacement, sign-extended and scaled by four. The displacement field is 8, 16 or 24 bits wide depending on the class. Indirect jumps take their destination from a register operand, also aligned to a word. The result is presented one clock after a valid request, together with a strobe. Fetch redirection, flushing and the register-file write are left to the surrounding pipeline.

Top module: `branch_link_unit`

## Requirements
- R1: While reset is high, and on the first clock after it, out_valid, taken, target, link_we and link_data are all zero.
- R2: out_valid is high exactly in the cycle after a cycle with in_valid high. The other outputs change only after a valid request and hold their values otherwise.
- R3: br_class 0 is a short flag branch. It uses disp[7:0] as a signed word offset and ignores disp[23:8]. A taken target is (pc with bits 1:0 cleared) + (sign-extended offset × 4), computed modulo 2^32.
- R4: br_class 1 is a register-compare branch with a signed 16-bit offset taken from disp[15:0]. The cond_sel values are: 0 opa==opb, 1 opa!=opb, 2 opa==0, 3 opa!=0, 4 opa<0, 5 opa>=0, 6 opa<=0, 7 opa>0. All comparisons are two's-complement signed.
- R5: br_class 2 is a long flag branch with a 24-bit offset sign-extended from disp[23]. For classes 0 and 2 the cond_sel values are: 0 taken when flag is 1, 1 taken when flag is 0, 2 always taken, 3 branch-and-link. Values 4 to 7 are never taken.
- R6: Branch-and-link (class 0 or 2, cond_sel 3) is always taken. It raises link_we with link_data = (pc with bits 1:0 cleared) + 4 and link_idx = 14.
- R7: br_class 3 is a register jump. It is always taken and its target is opa with bits 1:0 cleared. cond_sel[0]=1 also writes the link value of R6, and cond_sel[2:1] are ignored.
- R8: A transfer that is not taken gives target = (pc with bits 1:0 cleared) + 4 and link_we = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| pc | input | 32 | Instruction address |
| br_class | input | 2 | 0 short flag, 1 register compare, 2 long flag, 3 register jump |
| cond_sel | input | 3 | Condition selector |
| disp | input | 24 | Signed word displacement (low bits used per class) |
| opa | input | 32 | First register operand / jump base |
| opb | input | 32 | Second register operand |
| flag | input | 1 | Condition flag |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| taken | output | 1 | Transfer taken |
| target | output | 32 | Next instruction address |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 4 | Link register index (14) |
| link_data | output | 32 | Return address |

## Verification
The bench builds the unit with its default widths: a 32-bit datapath and displacement fields of 8, 16 and 24 bits. These widths put the sign bit of each field within reach of a directed test: the most negative offsets, a backward branch that wraps below address zero, and junk in the displacement bits a class must ignore. With full 32-bit operands, the signed comparisons can also be exercised at the boundary between 0x7FFFFFFF and 0x80000000, where signed and unsigned ordering disagree.

// File: rtl/blt_pkg.sv
package blt_pkg;

    typedef enum logic [1:0] {
        CLS_SHORT = 2'd0,
        CLS_CMP   = 2'd1,
        CLS_LONG  = 2'd2,
        CLS_JUMP  = 2'd3
    } br_class_e;

    typedef enum logic [2:0] {
        CMP_EQ  = 3'd0,
        CMP_NE  = 3'd1,
        CMP_EZ  = 3'd2,
        CMP_NZ  = 3'd3,
        CMP_LTZ = 3'd4,
        CMP_GEZ = 3'd5,
        CMP_LEZ = 3'd6,
        CMP_GTZ = 3'd7
    } cmp_sel_e;

    typedef enum logic [2:0] {
        FLG_SET    = 3'd0,
        FLG_CLEAR  = 3'd1,
        FLG_ALWAYS = 3'd2,
        FLG_LINK   = 3'd3
    } flag_sel_e;

    localparam int NUM_FORMATS = 3;

    typedef struct packed {
        logic taken;
        logic link;
    } decision_t;

    function automatic int disp_width(int idx, int s_w, int m_w, int l_w);
        if (idx == 0) return s_w;
        if (idx == 1) return m_w;
        return l_w;
    endfunction

endpackage

// File: rtl/blt_target_gen.sv
module blt_target_gen
    import blt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int S_W    = 8,
    parameter int M_W    = 16,
    parameter int L_W    = 24
) (
    input  logic [DATA_W-1:0]                  pc,
    input  logic [L_W-1:0]                     disp,
    output logic [DATA_W-1:0]                  aligned,
    output logic [DATA_W-1:0]                  seq,
    output logic [NUM_FORMATS-1:0][DATA_W-1:0] rel
);
    localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(4);

    assign aligned = {pc[DATA_W-1:2], 2'b00};
    assign seq     = aligned + WORD_BYTES;

    for (genvar g = 0; g < NUM_FORMATS; g++) begin : g_fmt
        localparam int W = disp_width(g, S_W, M_W, L_W);
        logic [DATA_W-1:0] ext;
        assign ext    = {{(DATA_W - W){disp[W-1]}}, disp[W-1:0]};
        assign rel[g] = aligned + {ext[DATA_W-3:0], 2'b00};
    end
endmodule

// File: rtl/blt_cond_eval.sv
module blt_cond_eval
    import blt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  br_class_e          cls,
    input  logic [2:0]         sel,
    input  logic [DATA_W-1:0]  opa,
    input  logic [DATA_W-1:0]  opb,
    input  logic               flag,
    output decision_t          dec
);
    logic signed [DATA_W-1:0] sa;
    logic                     a_zero;
    logic                     a_neg;
    logic                     cmp_hit;
    logic                     flg_hit;

    assign sa     = $signed(opa);
    assign a_zero = (opa == '0);
    assign a_neg  = (sa < 0);

    always_comb begin
        unique case (cmp_sel_e'(sel))
            CMP_EQ:  cmp_hit = (opa == opb);
            CMP_NE:  cmp_hit = (opa != opb);
            CMP_EZ:  cmp_hit = a_zero;
            CMP_NZ:  cmp_hit = !a_zero;
            CMP_LTZ: cmp_hit = a_neg;
            CMP_GEZ: cmp_hit = !a_neg;
            CMP_LEZ: cmp_hit = a_neg || a_zero;
            CMP_GTZ: cmp_hit = !a_neg && !a_zero;
            default: cmp_hit = 1'b0;
        endcase
    end

    always_comb begin
        case (sel)
            FLG_SET:    flg_hit = flag;
            FLG_CLEAR:  flg_hit = !flag;
            FLG_ALWAYS: flg_hit = 1'b1;
            FLG_LINK:   flg_hit = 1'b1;
            default:    flg_hit = 1'b0;
        endcase
    end

    always_comb begin
        dec = '0;
        unique case (cls)
            CLS_SHORT, CLS_LONG: begin
                dec.taken = flg_hit;
                dec.link  = (sel == FLG_LINK);
            end
            CLS_CMP: begin
                dec.taken = cmp_hit;
                dec.link  = 1'b0;
            end
            CLS_JUMP: begin
                dec.taken = 1'b1;
                dec.link  = sel[0];
            end
            default: dec = '0;
        endcase
    end
endmodule

// File: rtl/branch_link_unit.sv
module branch_link_unit
    import blt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int S_W      = 8,
    parameter int M_W      = 16,
    parameter int L_W      = 24,
    parameter int IDX_W    = 4,
    parameter int LINK_IDX = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] pc,
    input  logic [1:0]        br_class,
    input  logic [2:0]        cond_sel,
    input  logic [L_W-1:0]    disp,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              flag,
    output logic              out_valid,
    output logic              taken,
    output logic [DATA_W-1:0] target,
    output logic              link_we,
    output logic [IDX_W-1:0]  link_idx,
    output logic [DATA_W-1:0] link_data
);
    typedef struct packed {
        logic              taken;
        logic [DATA_W-1:0] target;
        logic              link_we;
        logic [DATA_W-1:0] link_data;
    } result_t;

    br_class_e                         cls;
    logic [DATA_W-1:0]                 aligned;
    logic [DATA_W-1:0]                 seq;
    logic [NUM_FORMATS-1:0][DATA_W-1:0] rel;
    decision_t                         dec;
    logic [DATA_W-1:0]                 taken_addr;
    result_t                           nxt;
    result_t                           cur;

    assign cls = br_class_e'(br_class);

    blt_target_gen #(
        .DATA_W (DATA_W),
        .S_W    (S_W),
        .M_W    (M_W),
        .L_W    (L_W)
    ) u_tgt (
        .pc      (pc),
        .disp    (disp),
        .aligned (aligned),
        .seq     (seq),
        .rel     (rel)
    );

    blt_cond_eval #(
        .DATA_W (DATA_W)
    ) u_cond (
        .cls  (cls),
        .sel  (cond_sel),
        .opa  (opa),
        .opb  (opb),
        .flag (flag),
        .dec  (dec)
    );

    always_comb begin
        unique case (cls)
            CLS_SHORT: taken_addr = rel[0];
            CLS_CMP:   taken_addr = rel[1];
            CLS_LONG:  taken_addr = rel[2];
            CLS_JUMP:  taken_addr = {opa[DATA_W-1:2], 2'b00};
            default:   taken_addr = seq;
        endcase
    end

    always_comb begin
        nxt.taken     = dec.taken;
        nxt.target    = dec.taken ? taken_addr : seq;
        nxt.link_we   = dec.taken && dec.link;
        nxt.link_data = seq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            cur       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                cur <= nxt;
            end
        end
    end

    assign taken     = cur.taken;
    assign target    = cur.target;
    assign link_we   = cur.link_we;
    assign link_data = cur.link_data;
    assign link_idx  = IDX_W'(LINK_IDX);
endmodule

// File: rtl/blt_checker.sv
module blt_checker #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        br_class,
    input logic [2:0]        cond_sel,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic              out_valid,
    input logic              taken,
    input logic [DATA_W-1:0] target,
    input logic              link_we
);
    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(target) && $stable(taken)));

    // R3
    target_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (target[1:0] == 2'b00));

    // R4
    cmp_equal_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && br_class == 2'd1 && cond_sel == 3'd0 && opa == opb) |=> taken);

    // R6
    bl_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && br_class == 2'd2 && cond_sel == 3'd3) |=> (taken && link_we));

    // R7
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && br_class == 2'd3) |=>
            (taken && target == {$past(opa[DATA_W-1:2]), 2'b00}));

    // R8
    no_link_untaken_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !taken) |-> !link_we);
endmodule

bind branch_link_unit blt_checker #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .br_class  (br_class),
    .cond_sel  (cond_sel),
    .opa       (opa),
    .opb       (opb),
    .out_valid (out_valid),
    .taken     (taken),
    .target    (target),
    .link_we   (link_we)
);

// File: tb/sim_branch_link_unit.sv
`timescale 1ns/1ps
module sim_branch_link_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] pc = '0;
    logic [1:0]  br_class = '0;
    logic [2:0]  cond_sel = '0;
    logic [23:0] disp = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        flag = 1'b0;
    logic        out_valid;
    logic        taken;
    logic [31:0] target;
    logic        link_we;
    logic [3:0]  link_idx;
    logic [31:0] link_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    branch_link_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .pc(pc), .br_class(br_class),
        .cond_sel(cond_sel), .disp(disp), .opa(opa), .opb(opb), .flag(flag),
        .out_valid(out_valid), .taken(taken), .target(target), .link_we(link_we),
        .link_idx(link_idx), .link_data(link_data)
    );

    function automatic logic [31:0] rel(logic [31:0] a, logic [23:0] d, int w);
        logic [31:0] x;
        x = 32'(d) << (32 - w);
        x = 32'($signed(x) >>> (32 - w));
        return (a & 32'hFFFF_FFFC) + (x << 2);
    endfunction

    function automatic logic [31:0] nxt(logic [31:0] a);
        return (a & 32'hFFFF_FFFC) + 32'd4;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic issue(logic [31:0] a, logic [1:0] c, logic [2:0] s, logic [23:0] d,
                         logic [31:0] x, logic [31:0] y, logic f);
        @(negedge clk);
        pc = a; br_class = c; cond_sel = s; disp = d; opa = x; opb = y; flag = f;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_res(string req, logic t, logic [31:0] tgt, logic lw, logic [31:0] ld);
        chk(req, "out_valid", 32'(out_valid), 32'd1);
        chk(req, "taken", 32'(taken), 32'(t));
        chk(req, "target", target, tgt);
        chk(req, "link_we", 32'(link_we), 32'(lw));
        if (lw) begin
            chk(req, "link_data", link_data, ld);
            chk(req, "link_idx", 32'(link_idx), 32'd14);
        end
    endtask

    task automatic t_reset();
        chk("R1", "out_valid", 32'(out_valid), 32'd0);
        chk("R1", "taken", 32'(taken), 32'd0);
        chk("R1", "target", target, 32'd0);
        chk("R1", "link_we", 32'(link_we), 32'd0);
        chk("R1", "link_data", link_data, 32'd0);
    endtask

    task automatic t_short();
        // R3: forward, backward, upper disp bits ignored
        issue(32'h0000_1002, 2'd0, 3'd2, 24'h000005, '0, '0, 1'b0);
        expect_res("R3", 1'b1, 32'h0000_1014, 1'b0, '0);
        issue(32'h0000_1003, 2'd0, 3'd0, 24'hABCD80, '0, '0, 1'b1);
        expect_res("R3", 1'b1, rel(32'h0000_1003, 24'h000080, 8), 1'b0, '0);
        chk("R3", "most negative", target, 32'h0000_0E00);
        issue(32'h0000_0004, 2'd0, 3'd2, 24'h0000FE, '0, '0, 1'b0);
        expect_res("R3", 1'b1, 32'hFFFF_FFFC, 1'b0, '0);
    endtask

    task automatic t_cmp();
        logic [31:0] a0;
        a0 = 32'h0000_2000;
        // R4: each selector, taken and untaken, signed boundaries
        issue(a0, 2'd1, 3'd0, 24'h007FFF, 32'd9, 32'd9, 1'b0);
        expect_res("R4", 1'b1, rel(a0, 24'h007FFF, 16), 1'b0, '0);
        issue(a0, 2'd1, 3'd0, 24'hFF8000, 32'd9, 32'd8, 1'b0);
        expect_res("R4", 1'b0, nxt(a0), 1'b0, '0);
        issue(a0, 2'd1, 3'd1, 24'hFF8000, 32'd9, 32'd8, 1'b0);
        expect_res("R4", 1'b1, rel(a0, 24'h008000, 16), 1'b0, '0);
        issue(a0, 2'd1, 3'd2, 24'h000010, 32'd0, '0, 1'b0);
        expect_res("R4", 1'b1, a0 + 32'h40, 1'b0, '0);
        issue(a0, 2'd1, 3'd3, 24'h000010, 32'd0, '0, 1'b0);
        expect_res("R4", 1'b0, nxt(a0), 1'b0, '0);
        issue(a0, 2'd1, 3'd4, 24'h000010, 32'h8000_0000, '0, 1'b0);
        expect_res("R4", 1'b1, a0 + 32'h40, 1'b0, '0);
        issue(a0, 2'd1, 3'd4, 24'h000010, 32'h7FFF_FFFF, '0, 1'b0);
        expect_res("R4", 1'b0, nxt(a0), 1'b0, '0);
        issue(a0, 2'd1, 3'd5, 24'h000010, 32'd0, '0, 1'b0);
        expect_res("R4", 1'b1, a0 + 32'h40, 1'b0, '0);
        issue(a0, 2'd1, 3'd6, 24'h000010, 32'd0, '0, 1'b0);
        expect_res("R4", 1'b1, a0 + 32'h40, 1'b0, '0);
        issue(a0, 2'd1, 3'd6, 24'h000010, 32'd1, '0, 1'b0);
        expect_res("R4", 1'b0, nxt(a0), 1'b0, '0);
        issue(a0, 2'd1, 3'd7, 24'h000010, 32'h7FFF_FFFF, '0, 1'b0);
        expect_res("R4", 1'b1, a0 + 32'h40, 1'b0, '0);
        issue(a0, 2'd1, 3'd7, 24'h000010, 32'hFFFF_FFFF, '0, 1'b0);
        expect_res("R4", 1'b0, nxt(a0), 1'b0, '0);
    endtask

    task automatic t_long();
        logic [31:0] a0;
        a0 = 32'h0100_0008;
        // R5: flag conditions, 24-bit sign extension, reserved selectors
        issue(a0, 2'd2, 3'd0, 24'h800000, '0, '0, 1'b1);
        expect_res("R5", 1'b1, rel(a0, 24'h800000, 24), 1'b0, '0);
        issue(a0, 2'd2, 3'd0, 24'h000100, '0, '0, 1'b0);
        expect_res("R5", 1'b0, nxt(a0), 1'b0, '0);
        issue(a0, 2'd2, 3'd1, 24'h7FFFFF, '0, '0, 1'b0);
        expect_res("R5", 1'b1, rel(a0, 24'h7FFFFF, 24), 1'b0, '0);
        issue(a0, 2'd2, 3'd2, 24'hFFFFFE, '0, '0, 1'b1);
        expect_res("R5", 1'b1, a0 - 32'd8, 1'b0, '0);
        issue(a0, 2'd2, 3'd5, 24'h000100, '0, '0, 1'b1);
        expect_res("R5", 1'b0, nxt(a0), 1'b0, '0);
        // R8: untaken never links even in short class
        issue(a0, 2'd0, 3'd7, 24'h000001, '0, '0, 1'b0);
        expect_res("R8", 1'b0, nxt(a0), 1'b0, '0);
    endtask

    task automatic t_link();
        // R6: branch-and-link in both flag classes
        issue(32'h0000_3006, 2'd2, 3'd3, 24'h000040, '0, '0, 1'b0);
        expect_res("R6", 1'b1, 32'h0000_3104, 1'b1, 32'h0000_3008);
        issue(32'h0000_300B, 2'd0, 3'd3, 24'h0000FF, '0, '0, 1'b1);
        expect_res("R6", 1'b1, 32'h0000_3004, 1'b1, 32'h0000_300C);
    endtask

    task automatic t_jump();
        // R7: plain jump, jump-and-link, ignored upper selector bits
        issue(32'h0000_4000, 2'd3, 3'd0, 24'h123456, 32'h0000_8ABF, '0, 1'b0);
        expect_res("R7", 1'b1, 32'h0000_8ABC, 1'b0, '0);
        issue(32'h0000_4001, 2'd3, 3'd1, 24'h000000, 32'hFFFF_FFFF, '0, 1'b0);
        expect_res("R7", 1'b1, 32'hFFFF_FFFC, 1'b1, 32'h0000_4004);
        issue(32'h0000_4001, 2'd3, 3'd6, 24'h000000, 32'h0000_0123, '0, 1'b1);
        expect_res("R7", 1'b1, 32'h0000_0120, 1'b0, '0);
    endtask

    task automatic t_hold();
        logic [31:0] keep;
        // R2: without a request the strobe stays low and results hold
        issue(32'h0000_5000, 2'd0, 3'd2, 24'h000003, '0, '0, 1'b0);
        keep = target;
        pc = 32'h0000_9990; br_class = 2'd3; opa = 32'h0000_7770;
        repeat (3) @(negedge clk);
        chk("R2", "out_valid idle", 32'(out_valid), 32'd0);
        chk("R2", "target held", target, keep);
        chk("R2", "taken held", 32'(taken), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_short();
        t_cmp();
        t_long();
        t_link();
        t_jump();
        t_hold();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule